// File: doc/BRIEF.md
# Reset-Time Configuration Byte Loader

After reset this block fetches configuration bytes from a small serial EEPROM and turns them into the values of the bus configuration registers. It reaches the EEPROM through a simple byte-read port. The loader raises a request with an address, and the EEPROM side answers with a one-cycle data-valid strobe that carries the byte.

The first byte fetched is a field-enable byte. It decides which of the later fields are read at all. Disabled fields are skipped entirely and their registers take fixed defaults. A done flag marks the point where the register outputs hold their final values.

If the EEPROM stops answering, a cycle limit ends the sequence. Every field then falls back to its default and done is still raised, so the rest of the chip never waits forever for configuration.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Right after reset release the loader requests address 0x00 before any other address. It keeps only one request outstanding, and holds the address steady until the data-valid strobe arrives.
- R2: The loader requests only 0x00 and the enabled addresses within 0x04..0x0a, in strictly ascending order. It never requests an address of 0x20 or above, and it issues exactly one read per enabled byte.
- R3: When field-enable bit 0 is 1, the subsystem vendor ID is {byte 0x05, byte 0x04}, with 0x04 as the low byte. When the bit is 0, the ID is 16'h0000.
- R4: When field-enable bit 1 is 1, the subsystem ID is {byte 0x07, byte 0x06}. When the bit is 0, the ID is 16'h0000.
- R5: When field-enable bit 2 is 1, the power-management capability bit (status bit 20) reads 0. Otherwise it reads 1.
- R6: When field-enable bit 3 is 1, byte 0x08 drives five outputs. Bit 0 drives memory-space enable, bit 1 bus-master enable, bit 2 parity-check enable, bit 3 master-control byte swap and bit 4 slave-control byte swap. When field-enable bit 3 is 0, all five outputs are 0.
- R7: When field-enable bit 4 is 1, the latency timer is byte 0x09. Otherwise it is 0.
- R8: When field-enable bit 5 is 1, the size mask is byte 0x0a. Otherwise it is 0. The 8 MB window flag is 1 exactly when size mask bits 6:0 are all 0, regardless of bit 7.
- R9: Done rises once the last enabled byte has been received and stays high until reset. The request is low while done is high, and a data-valid strobe that arrives after done changes no output. Field-enable bits 6 and 7 have no effect.
- R10: If no data-valid strobe arrives within TIMEOUT_CYCLES cycles of a pending request, the loader raises done. It then leaves every field at its default: IDs 0, general enables 0, latency 0, mask 0, power-management bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | output | 1 | Byte read request pending |
| rd_addr | output | AW | Byte address of the pending request |
| rd_valid | input | 1 | One-cycle strobe, rd_data is valid |
| rd_data | input | 8 | Byte returned by the EEPROM |
| sub_vendor_id | output | 16 | Subsystem vendor ID |
| sub_id | output | 16 | Subsystem ID |
| pm_cap_present | output | 1 | Status bit 20, power-management capability |
| cmd_mem_space | output | 1 | Command bit 1, memory-space enable |
| cmd_bus_master | output | 1 | Command bit 2, bus-master enable |
| cmd_parity_chk | output | 1 | Command bit 6, parity-error detection enable |
| swap_master_ctl | output | 1 | Special status bit 30, master control byte swap |
| swap_slave_ctl | output | 1 | Special status bit 29, slave control byte swap |
| latency_timer | output | 8 | Master latency timer |
| size_mask | output | 8 | Memory size mask |
| size_is_8mb | output | 1 | Mask bits 6:0 select the 8 MB window |
| load_done | output | 1 | Loading finished (completed or aborted) |

## Verification
A wrong step index shows up at once on rd_addr: a skipped, repeated or out-of-order address appears on the request that follows the faulty strobe. A corrupted field-enable copy or a capture into the wrong register only becomes visible when load_done rises, because the outputs stay at their defaults until then. The bench therefore sweeps all 256 field-enable values and compares every field and the full address trace at that point. A broken timeout counter shows as done arriving too early, too late or never after the EEPROM stops answering.

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int TIMEOUT_CYCLES = 64,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic [15:0]   sub_vendor_id,
  output logic [15:0]   sub_id,
  output logic          pm_cap_present,
  output logic          cmd_mem_space,
  output logic          cmd_bus_master,
  output logic          cmd_parity_chk,
  output logic          swap_master_ctl,
  output logic          swap_slave_ctl,
  output logic [7:0]    latency_timer,
  output logic [7:0]    size_mask,
  output logic          size_is_8mb,
  output logic          load_done
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST_WAIT = CW'(TIMEOUT_CYCLES - 1);

  // step 0 reads the enable byte, steps 1..7 read addresses 0x04..0x0a
  logic [2:0]    step;
  logic [5:0]    fen;
  logic [15:0]   svid_q, sid_q;
  logic [4:0]    gen_q;
  logic [7:0]    lat_q, msk_q;
  logic          done_q, ok_q;
  logic [CW-1:0] wcnt;

  logic [5:0] fsrc;
  logic [7:1] en;
  logic [2:0] nxt;
  logic       has_nxt;

  assign fsrc = (step == 3'd0) ? rd_data[5:0] : fen;
  assign en   = {fsrc[5], fsrc[4], fsrc[3], fsrc[1], fsrc[1], fsrc[0], fsrc[0]};

  always_comb begin
    nxt = 3'd0;
    has_nxt = 1'b0;
    for (int k = 7; k >= 1; k--) begin
      if (k > int'(step) && en[k]) begin
        nxt = 3'(k);
        has_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step   <= 3'd0;
      fen    <= '0;
      svid_q <= '0;
      sid_q  <= '0;
      gen_q  <= '0;
      lat_q  <= '0;
      msk_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      wcnt   <= '0;
    end else if (!done_q) begin
      if (rd_valid) begin
        wcnt <= '0;
        case (step)
          3'd0: fen          <= rd_data[5:0];
          3'd1: svid_q[7:0]  <= rd_data;
          3'd2: svid_q[15:8] <= rd_data;
          3'd3: sid_q[7:0]   <= rd_data;
          3'd4: sid_q[15:8]  <= rd_data;
          3'd5: gen_q        <= rd_data[4:0];
          3'd6: lat_q        <= rd_data;
          default: msk_q     <= rd_data;
        endcase
        if (has_nxt) begin
          step <= nxt;
        end else begin
          done_q <= 1'b1;
          ok_q   <= 1'b1;
        end
      end else if (wcnt == LAST_WAIT) begin
        done_q <= 1'b1;
        ok_q   <= 1'b0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  logic ld;
  assign ld = done_q & ok_q;

  assign rd_req  = ~done_q;
  assign rd_addr = (step == 3'd0) ? '0 : AW'({1'b0, step} + 4'd3);

  assign sub_vendor_id   = (ld & fen[0]) ? svid_q : 16'h0000;
  assign sub_id          = (ld & fen[1]) ? sid_q  : 16'h0000;
  assign pm_cap_present  = ~(ld & fen[2]);
  assign cmd_mem_space   = ld & fen[3] & gen_q[0];
  assign cmd_bus_master  = ld & fen[3] & gen_q[1];
  assign cmd_parity_chk  = ld & fen[3] & gen_q[2];
  assign swap_master_ctl = ld & fen[3] & gen_q[3];
  assign swap_slave_ctl  = ld & fen[3] & gen_q[4];
  assign latency_timer   = (ld & fen[4]) ? lat_q : 8'h00;
  assign size_mask       = (ld & fen[5]) ? msk_q : 8'h00;
  assign size_is_8mb     = (size_mask[6:0] == 7'd0);
  assign load_done       = done_q;

  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr < AW'(32));

  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (!rd_req || rd_addr > $past(rd_addr)));

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (!rd_req || $stable(rd_addr)));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> (load_done && !rd_req));

  assert_frozen_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_done) |-> ($stable(sub_vendor_id) && $stable(sub_id) && $stable(latency_timer)
                          && $stable(size_mask) && $stable(pm_cap_present)));

  assert_svid_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !fen[0]) |-> sub_vendor_id == 16'h0000);

  assert_wait_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt < CW'(TIMEOUT_CYCLES));

  assert_abort_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !ok_q) |-> (pm_cap_present && sub_id == 16'h0000 && size_mask == 8'h00));
endmodule

// File: tb/eeprom_cfg_loader_bench.sv
module eeprom_cfg_loader_bench;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        rd_req, rd_valid;
  logic [6:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [15:0] svid, sid;
  logic        pm, c_mem, c_bm, c_par, sw_m, sw_s, win8, done;
  logic [7:0]  lat, msk;

  eeprom_cfg_loader #(.TIMEOUT_CYCLES(TMO), .AW(7)) u_eeprom_cfg_loader (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .sub_vendor_id(svid), .sub_id(sid),
    .pm_cap_present(pm), .cmd_mem_space(c_mem), .cmd_bus_master(c_bm),
    .cmd_parity_chk(c_par), .swap_master_ctl(sw_m), .swap_slave_ctl(sw_s),
    .latency_timer(lat), .size_mask(msk), .size_is_8mb(win8), .load_done(done));

  logic [7:0] mem [0:127];
  int lat_cfg = 0;
  int mute_after = 1000;
  logic inj_req = 1'b0;
  logic inj_ack;
  int wcyc;
  int log_n;
  logic [6:0] addr_log [0:15];

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
      wcyc     <= 0;
      log_n    <= 0;
      inj_ack  <= inj_req;
    end else begin
      rd_valid <= 1'b0;
      if (inj_req != inj_ack) begin
        rd_valid <= 1'b1;
        rd_data  <= 8'hA5;
        inj_ack  <= inj_req;
      end else if (rd_req && !rd_valid && log_n < mute_after) begin
        if (wcyc >= lat_cfg) begin
          rd_valid <= 1'b1;
          rd_data  <= mem[rd_addr];
          if (log_n < 16) addr_log[log_n] <= rd_addr;
          log_n <= log_n + 1;
          wcyc  <= 0;
        end else begin
          wcyc <= wcyc + 1;
        end
      end
    end
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_defaults(input string tag);
    chk(svid == 16'h0 && sid == 16'h0, {tag, " ids"}, {svid, sid}, 32'h0);
    chk(pm == 1'b1, {tag, " pm"}, 32'(pm), 32'h1);
    chk({c_mem, c_bm, c_par, sw_m, sw_s} == 5'h0, {tag, " gen"}, 32'({c_mem, c_bm, c_par, sw_m, sw_s}), 32'h0);
    chk(lat == 8'h0 && msk == 8'h0 && win8, {tag, " lat/msk"}, {15'h0, win8, lat, msk}, 32'h10000);
  endtask

  task automatic run_case(input logic [7:0] fe, input int lv, input int mute, input int seed);
    logic [15:0] e_svid, e_sid;
    logic [4:0]  e_gen;
    logic [7:0]  e_lat, e_msk;
    logic [6:0]  e_addr [0:15];
    int e_n;
    int cyc;
    for (int a = 0; a < 128; a++) mem[a] = 8'((a * 37 + seed * 11 + 5));
    mem[0] = fe;
    if (seed % 3 == 0) mem[10] = 8'h80;
    lat_cfg = lv;
    mute_after = mute;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done, "R9 reset done", 32'(done), 32'h0);
    check_defaults("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_req && rd_addr == 7'h00, "R1 first request", {24'h0, rd_req, rd_addr}, 32'h80);
    cyc = 0;
    while (!done && cyc < 600) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R9 done reached", 32'(done), 32'h1);
    chk(!rd_req, "R9 request dropped", 32'(rd_req), 32'h0);
    e_n = 1;
    e_addr[0] = 7'h00;
    if (fe[0]) begin e_addr[e_n] = 7'h04; e_addr[e_n+1] = 7'h05; e_n += 2; end
    if (fe[1]) begin e_addr[e_n] = 7'h06; e_addr[e_n+1] = 7'h07; e_n += 2; end
    if (fe[3]) begin e_addr[e_n] = 7'h08; e_n++; end
    if (fe[4]) begin e_addr[e_n] = 7'h09; e_n++; end
    if (fe[5]) begin e_addr[e_n] = 7'h0a; e_n++; end
    if (mute < e_n) begin
      chk(cyc >= TMO - 2 && cyc <= (mute + 1) * (lv + 2) + TMO + 8, "R10 abort time", 32'(cyc), 32'(TMO));
      check_defaults("R10 aborted");
    end else begin
      chk(log_n == e_n, "R2 read count", 32'(log_n), 32'(e_n));
      for (int i = 0; i < e_n && i < log_n; i++)
        chk(addr_log[i] == e_addr[i], "R2 address order", 32'(addr_log[i]), 32'(e_addr[i]));
      e_svid = fe[0] ? {mem[5], mem[4]} : 16'h0;
      e_sid  = fe[1] ? {mem[7], mem[6]} : 16'h0;
      e_gen  = fe[3] ? mem[8][4:0] : 5'h0;
      e_lat  = fe[4] ? mem[9] : 8'h0;
      e_msk  = fe[5] ? mem[10] : 8'h0;
      chk(svid == e_svid, "R3 vendor id", 32'(svid), 32'(e_svid));
      chk(sid == e_sid, "R4 subsystem id", 32'(sid), 32'(e_sid));
      chk(pm == !fe[2], "R5 pm bit", 32'(pm), 32'(!fe[2]));
      chk({sw_s, sw_m, c_par, c_bm, c_mem} == e_gen, "R6 general enables",
          32'({sw_s, sw_m, c_par, c_bm, c_mem}), 32'(e_gen));
      chk(lat == e_lat, "R7 latency", 32'(lat), 32'(e_lat));
      chk(msk == e_msk, "R8 size mask", 32'(msk), 32'(e_msk));
      chk(win8 == (e_msk[6:0] == 7'h0), "R8 8MB flag", 32'(win8), 32'(e_msk[6:0] == 7'h0));
    end
  endtask

  initial begin
    for (int f = 0; f < 256; f++) run_case(8'(f), f % 4, 1000, f);
    run_case(8'h3F, 1, 0, 7);
    run_case(8'h3F, 2, 3, 8);
    run_case(8'h20, 0, 1, 9);
    run_case(8'hFF, 0, 1000, 12);
    begin
      logic [15:0] s0;
      logic [7:0]  l0, m0;
      s0 = svid; l0 = lat; m0 = msk;
      @(negedge clk);
      inj_req = ~inj_req;
      repeat (3) @(negedge clk);
      chk(svid == s0 && lat == l0 && msk == m0 && done, "R9 late strobe ignored",
          {svid, l0, msk}, {s0, l0, m0});
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule